// File: doc/BRIEF.md
# Pipelined Phase Accumulator with Phase Offset

This block is the timing core of a numerically controlled oscillator. It keeps a wide running sum of a frequency word, one addition per clock. The top bits of that sum are an evenly advancing phase whose wrap rate sets the output frequency. To keep the adder short at high clock rates, the sum is split into equal slices. Each slice has its own adder, its own sum register and a registered carry into the next slice up. A carry therefore reaches the next slice one clock later.

Because of that slicing, the caller must present the frequency word skewed. The byte for slice k is presented k clocks later than the byte for slice 0. The most significant slice register is the quantized phase. A second, registered adder then adds an offset word to that phase to produce a modulated phase. Single-bit square-wave sine and cosine signals are decoded from both the raw phase and the modulated phase.

Top module: `nco_pipe_accum`

## Requirements
- R1: A synchronous active-high reset clears every slice, carry and modulation register, so that after a reset edge `phase_o` and `mod_phase_o` are 0 and all four square-wave outputs are 0, whatever the inputs are.
- R2: Let A(t) be the modulo-2^32 sum of the intended frequency words F(1)..F(t), with A(t)=0 for t<=0, where t counts clock edges since reset. Then after edge t, `phase_o` equals bits [31:24] of A(t-3).
- R3: Slice k (k = 0..3) adds bits [8k+7:8k] of `freq_skew_i`, and at edge t those bits must hold byte k of F(t-k). When this skew is respected, a frequency word that changes on every clock still yields exactly the phase of R2.
- R4: A carry out of any slice enters the next more significant slice exactly one edge later, so carries ripple correctly through all four slices (for example with F = 0x00FFFFFF).
- R5: The 32-bit accumulation wraps modulo 2^32 with no saturation and no lost step (for example F = 0x80000000 or 0xC0000000).
- R6: `sin_o` is 1 exactly when `phase_o` is in 128..255, which is phase bit 7.
- R7: `cos_o` is 1 exactly when `phase_o` is in 64..191 (phase bit 7 XOR bit 6), a square wave a quarter period ahead of `sin_o`.
- R8: After each edge, `mod_phase_o` equals the `phase_o` value held before that edge plus the `phase_word_i` sampled at that edge, modulo 256. The carry out of this addition is discarded.
- R9: `mod_sin_o` and `mod_cos_o` decode `mod_phase_o` with the same ranges as R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| freq_skew_i | input | 32 | Frequency word; byte k must be delayed k clocks relative to byte 0 |
| phase_word_i | input | 8 | Phase offset added by the modulation stage |
| phase_o | output | 8 | Quantized phase (top slice register) |
| mod_phase_o | output | 8 | Registered phase plus offset |
| sin_o | output | 1 | Square-wave sine from the phase |
| cos_o | output | 1 | Square-wave cosine from the phase |
| mod_sin_o | output | 1 | Square-wave sine from the modulated phase |
| mod_cos_o | output | 1 | Square-wave cosine from the modulated phase |

## Verification
In a single cycle, a carry can arrive in a slice at the same moment that the slice's frequency byte changes. That same top-slice update also feeds the offset adder together with a new offset word. The bench provokes these overlaps by driving a fresh random frequency word on every clock (skewed byte by byte) and a fresh random offset word on every clock. It also uses words chosen to make every slice carry at once. Each clock, a behavioural running-sum model judges both the raw and the modulated phase and their square-wave decodes.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Quarter-wave square decode: high over the middle half of a turn.
   function automatic logic quad_cos(input logic msb, input logic nxt);
      return msb ^ nxt;
   endfunction

endpackage

// File: rtl/nco_acc_slice.sv
module nco_acc_slice #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] addend_i,
   input  logic         carry_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o
);

   logic [W-1:0] sum_q;
   logic         carry_q;
   logic [W:0]   total;

   assign total = {1'b0, sum_q} + {1'b0, addend_i} + {{W{1'b0}}, carry_i};

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sum_q   <= '0;
         carry_q <= 1'b0;
      end else begin
         sum_q   <= total[W-1:0];
         carry_q <= total[W];
      end
   end

   assign sum_o   = sum_q;
   assign carry_o = carry_q;

endmodule

// File: rtl/nco_phase_mod.sv
module nco_phase_mod #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] phase_i,
   input  logic [W-1:0] offset_i,
   output logic [W-1:0] mod_o
);

   logic [W-1:0] mod_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) mod_q <= '0;
      else       mod_q <= phase_i + offset_i;
   end

   assign mod_o = mod_q;

endmodule

// File: rtl/nco_square.sv
module nco_square #(
   parameter int W = 8
) (
   input  logic [W-1:0] phase_i,
   output logic         sin_o,
   output logic         cos_o
);
   import nco_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("nco_square: phase width must be at least 2");
   end

   logic unused_low;
   if (W > 2) begin : g_low
      assign unused_low = ^phase_i[W-3:0];
   end else begin : g_nolow
      assign unused_low = 1'b0;
   end

   assign sin_o = phase_i[W-1];
   assign cos_o = quad_cos(phase_i[W-1], phase_i[W-2]);

endmodule

// File: rtl/nco_pipe_accum.sv
module nco_pipe_accum #(
   parameter int SLICE_W    = 8,
   parameter int NUM_SLICES = 4
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic [SLICE_W*NUM_SLICES-1:0] freq_skew_i,
   input  logic [SLICE_W-1:0]            phase_word_i,
   output logic [SLICE_W-1:0]            phase_o,
   output logic [SLICE_W-1:0]            mod_phase_o,
   output logic                          sin_o,
   output logic                          cos_o,
   output logic                          mod_sin_o,
   output logic                          mod_cos_o
);

   localparam int ACC_W = SLICE_W * NUM_SLICES;
   localparam int CW    = (NUM_SLICES > 1) ? NUM_SLICES - 1 : 1;

   if (NUM_SLICES < 2) begin : g_bad_slices
      $error("nco_pipe_accum: at least two slices are required");
   end
   if (SLICE_W < 2) begin : g_bad_slice_w
      $error("nco_pipe_accum: slice width must be at least 2");
   end
   if (ACC_W > 64) begin : g_bad_acc
      $error("nco_pipe_accum: accumulator wider than 64 bits");
   end

   logic [CW-1:0]      carry_q;
   logic [SLICE_W-1:0] phase_q;

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      logic cin;
      if (k == 0) begin : g_lsb
         assign cin = 1'b0;
      end else begin : g_up
         assign cin = carry_q[k-1];
      end

      if (k == NUM_SLICES - 1) begin : g_msb
         logic carry_unused;
         nco_acc_slice #(.W(SLICE_W)) u_slice (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .addend_i (freq_skew_i[k*SLICE_W +: SLICE_W]),
            .carry_i  (cin),
            .sum_o    (phase_q),
            .carry_o  (carry_unused)
         );
      end else begin : g_low
         logic [SLICE_W-1:0] sum_unused;
         nco_acc_slice #(.W(SLICE_W)) u_slice (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .addend_i (freq_skew_i[k*SLICE_W +: SLICE_W]),
            .carry_i  (cin),
            .sum_o    (sum_unused),
            .carry_o  (carry_q[k])
         );
      end
   end

   nco_phase_mod #(.W(SLICE_W)) u_mod (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .phase_i  (phase_q),
      .offset_i (phase_word_i),
      .mod_o    (mod_phase_o)
   );

   nco_square #(.W(SLICE_W)) u_sq_raw (
      .phase_i (phase_q),
      .sin_o   (sin_o),
      .cos_o   (cos_o)
   );

   nco_square #(.W(SLICE_W)) u_sq_mod (
      .phase_i (mod_phase_o),
      .sin_o   (mod_sin_o),
      .cos_o   (mod_cos_o)
   );

   assign phase_o = phase_q;

endmodule

// File: rtl/nco_pipe_accum_chk.sv
module nco_pipe_accum_chk #(
   parameter int PW = 8
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic [PW-1:0] phase_word_i,
   input logic [PW-1:0] phase_o,
   input logic [PW-1:0] mod_phase_o,
   input logic          sin_o,
   input logic          cos_o,
   input logic          mod_sin_o,
   input logic          mod_cos_o
);

   p_sin_msb_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      sin_o == (phase_o >= PW'(1 << (PW-1))));

   p_cos_quad_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      cos_o == ((phase_o >= PW'(1 << (PW-2))) &&
                (phase_o <  PW'(3 << (PW-2)))));

   p_mod_sum_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> mod_phase_o == PW'($past(phase_o) + $past(phase_word_i)));

   p_mod_sin_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      mod_sin_o == (mod_phase_o >= PW'(1 << (PW-1))));

   p_mod_cos_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      mod_cos_o == ((mod_phase_o >= PW'(1 << (PW-2))) &&
                    (mod_phase_o <  PW'(3 << (PW-2)))));

endmodule

bind nco_pipe_accum nco_pipe_accum_chk #(.PW(SLICE_W)) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .phase_word_i (phase_word_i),
   .phase_o      (phase_o),
   .mod_phase_o  (mod_phase_o),
   .sin_o        (sin_o),
   .cos_o        (cos_o),
   .mod_sin_o    (mod_sin_o),
   .mod_cos_o    (mod_cos_o)
);

// File: tb/nco_pipe_accum_bench.sv
module nco_pipe_accum_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] freq_skew;
   logic [7:0]  pw;
   logic [7:0]  phase, mod_phase;
   logic        s, c, ms, mc;

   always #10 clk = ~clk;

   nco_pipe_accum u_nco_pipe_accum (
      .clk_i        (clk),
      .rst_i        (rst),
      .freq_skew_i  (freq_skew),
      .phase_word_i (pw),
      .phase_o      (phase),
      .mod_phase_o  (mod_phase),
      .sin_o        (s),
      .cos_o        (c),
      .mod_sin_o    (ms),
      .mod_cos_o    (mc)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] f_hist[$];
   logic [31:0] a_hist[$];
   logic [7:0]  exp_ph, exp_mod;

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit sq_sin(input logic [7:0] p);
      return p >= 8'd128;
   endfunction

   function automatic bit sq_cos(input logic [7:0] p);
      return (p >= 8'd64) && (p < 8'd192);
   endfunction

   task automatic compare_all(input string ph_tag);
      check(ph_tag, "phase", phase, exp_ph);
      check("R6", "sin", s, sq_sin(exp_ph));
      check("R7", "cos", c, sq_cos(exp_ph));
      check("R8", "mod_phase", mod_phase, exp_mod);
      check("R9", "mod_sin", ms, sq_sin(exp_mod));
      check("R9", "mod_cos", mc, sq_cos(exp_mod));
   endtask

   task automatic clear_model();
      f_hist = {32'h0};
      a_hist = {32'h0};
      exp_ph = 8'h0;
      exp_mod = 8'h0;
   endtask

   // One clock: F is the intended word for this edge; bytes are skewed here.
   task automatic step(input logic [31:0] f, input logic [7:0] p, input string tag);
      int t;
      f_hist.push_back(f);
      a_hist.push_back(a_hist[a_hist.size()-1] + f);
      t = f_hist.size() - 1;
      for (int k = 0; k < 4; k++) begin
         if (t - k >= 0) freq_skew[8*k +: 8] = f_hist[t-k][8*k +: 8];
         else            freq_skew[8*k +: 8] = 8'h0;
      end
      pw = p;
      exp_mod = exp_ph + p;
      exp_ph  = (t >= 3) ? a_hist[t-3][31:24] : 8'h0;
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      freq_skew = $urandom();
      pw = 8'($urandom());
      @(posedge clk);
      @(negedge clk);
      check("R1", "reset phase", phase, 0);
      check("R1", "reset mod_phase", mod_phase, 0);
      check("R1", "reset square bits", {s, c, ms, mc}, 0);
      rst = 1'b0;
      clear_model();
   endtask

   initial begin
      rst = 1'b1;
      freq_skew = '0;
      pw = '0;
      @(negedge clk);
      do_reset();

      // R2: unit step on the top byte
      for (int i = 0; i < 40; i++) step(32'h0100_0000, 8'h00, "R2");
      // R4: carries through every slice
      for (int i = 0; i < 60; i++) step(32'h00FF_FFFF, 8'h10, "R4");
      for (int i = 0; i < 30; i++) step(32'h0000_FFFF, 8'h00, "R4");
      // R5: wrap of the whole accumulator
      for (int i = 0; i < 16; i++) step(32'h8000_0000, 8'h00, "R5");
      for (int i = 0; i < 16; i++) step(32'hC000_0000, 8'h40, "R5");
      for (int i = 0; i < 16; i++) step(32'hFFFF_FFFF, 8'hFF, "R5");
      // R8: offset sweep over a slow phase
      for (int i = 0; i < 64; i++) step(32'h0400_0000, 8'(i * 37), "R2");
      // R3: new skewed word and new offset every clock
      for (int i = 0; i < 400; i++) step($urandom(), 8'($urandom()), "R3");
      // R1: reset in mid-run, then resume
      do_reset();
      for (int i = 0; i < 100; i++) step($urandom(), 8'($urandom()), "R3");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule